// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block decides when an embedded flash array has finished an erase or a program operation. After a command sequence has been issued elsewhere, a start strobe hands the block a flash address and a time limit in clock ticks. The block then reads the 16-bit status word at that address over a simple request/valid read port. It watches two status bits: the toggle flag, bit 6, which flips on every read while the array is busy, and the time-limit-exceeded flag, bit 5, which the array raises when its own internal operation has run too long.

Each polling round discards one read and keeps the next two. If the toggle bit agrees in the kept pair, the operation has finished. If the toggle bit disagrees and the first kept word shows the time-limit flag, two more reads decide between a late finish and a real failure. If the toggle bit disagrees and the flag is clear, a new round starts. A tick counter bounds the whole poll. The result is a one-cycle done pulse with a pass/fail flag and the elapsed tick count, both held until the next start. Typical limits are 500 ms for a single-sector operation and 20000 ms for a whole-array operation, which is polled at offset 0xAA8. The package converts both to ticks through a ticks-per-millisecond parameter.

Top module: `flash_toggle_poller`

## Requirements
- R1: A synchronous reset leaves the block idle: busy_o, done_o, pass_o and rd_req_o low, and elapsed_o zero. This holds even when the reset arrives in the middle of a poll.
- R2: rd_req_o is a one-cycle pulse carrying the latched address on rd_addr_o. Only one read is outstanding at a time, and the next request follows only after rd_valid_i. Every round is one discarded read followed by two kept reads.
- R3: When bit 6 (mask 0x0040) is equal in the two kept reads, the poll ends with pass, and no further read is issued.
- R4: When bit 6 differs in the kept pair and bit 5 (mask 0x0020) is set in the first kept read, exactly two more reads follow with no discarded read in between. The poll fails if bit 6 differs between those two and passes otherwise.
- R5: When bit 6 differs in the kept pair and bit 5 of the first kept read is clear, a new round begins with a discarded read.
- R6: Once elapsed_o exceeds the limit latched at start, the poll ends with fail. A timeout therefore reports elapsed_o equal to limit+1, and a limit of 0 fails with elapsed_o equal to 1.
- R7: If a read that yields a final verdict completes on the same edge where the timeout would fire, the verdict from the read wins.
- R8: done_o is high for exactly one cycle per poll. elapsed_o counts the edges after the accepting edge at which the poll kept running. pass_o and elapsed_o stay unchanged while idle until the next accepted start.
- R9: A start while busy is ignored. The running poll keeps its address, its limit and its result.
- R10: rd_valid_i while idle has no effect: busy_o, done_o, pass_o and elapsed_o do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a poll; taken only while idle |
| addr_i | input | ADDR_W | Flash address to poll, latched on start |
| limit_i | input | CNT_W | Time limit in ticks, latched on start |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Address of the requested read |
| rd_valid_i | input | 1 | Read data valid pulse |
| rd_data_i | input | DATA_W | Status word returned by the flash |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle end-of-poll pulse |
| pass_o | output | 1 | Result of the last poll, 1 = pass |
| elapsed_o | output | CNT_W | Ticks used by the current or last poll |

## Verification
The timeout check and the arrival of the read that settles the verdict can land on the same clock edge. The bench provokes this by replaying a completing poll with a fixed read latency and a generous limit, and it measures the elapsed count E. It then runs the same poll with limit E-1, where both events fall on one edge, and with limit E-2, where the timeout comes one edge earlier. The first must pass with elapsed E, and the second must fail with elapsed E-1.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT
   } seq_state_e;

   typedef enum logic [2:0] {
      PH_DUMMY,
      PH_KEEP_A,
      PH_KEEP_B,
      PH_RECHK_A,
      PH_RECHK_B
   } rd_phase_e;

   typedef enum logic [2:0] {
      ACT_NEXT,
      ACT_NEW_ROUND,
      ACT_RECHECK,
      ACT_PASS,
      ACT_FAIL
   } poll_act_e;

   localparam int unsigned SECTOR_LIMIT_MS   = 500;
   localparam int unsigned ARRAY_LIMIT_MS    = 20000;
   localparam int unsigned ARRAY_POLL_OFFSET = 32'h0000_0AA8;

   function automatic longint unsigned ms_to_ticks(input int unsigned ms,
                                                   input int unsigned ticks_per_ms);
      return longint'(ms) * longint'(ticks_per_ms);
   endfunction

   function automatic rd_phase_e phase_after(input rd_phase_e ph);
      case (ph)
         PH_DUMMY:   return PH_KEEP_A;
         PH_KEEP_A:  return PH_KEEP_B;
         PH_RECHK_A: return PH_RECHK_B;
         default:    return PH_DUMMY;
      endcase
   endfunction

endpackage

// File: rtl/ftp_tick_timer.sv
module ftp_tick_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] elapsed_o,
   output logic [CNT_W-1:0] limit_o,
   output logic             expired_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] elapsed_q;
   logic [CNT_W-1:0] limit_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         elapsed_q <= '0;
         limit_q   <= '0;
      end else if (clear_i) begin
         elapsed_q <= '0;
         limit_q   <= limit_i;
      end else if (run_i && (elapsed_q != CNT_MAX)) begin
         elapsed_q <= elapsed_q + 1'b1;
      end
   end

   assign expired_o = (elapsed_q > limit_q);
   assign elapsed_o = elapsed_q;
   assign limit_o   = limit_q;

endmodule

// File: rtl/ftp_toggle_judge.sv
module ftp_toggle_judge
   import ftp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int TOG_POS = 6,
   parameter int LIM_POS = 5
) (
   input  rd_phase_e         phase_i,
   input  logic [DATA_W-1:0] held_i,
   input  logic [DATA_W-1:0] fresh_i,
   output poll_act_e         act_o
);

   generate
      if (TOG_POS >= DATA_W || LIM_POS >= DATA_W || TOG_POS == LIM_POS) begin : g_bad_pos
         $error("ftp_toggle_judge: status bit positions must be distinct and inside DATA_W");
      end
   endgenerate

   logic tog_same;
   assign tog_same = (held_i[TOG_POS] == fresh_i[TOG_POS]);

   always_comb begin
      act_o = ACT_NEXT;
      case (phase_i)
         PH_KEEP_B: begin
            if (tog_same)              act_o = ACT_PASS;
            else if (held_i[LIM_POS])  act_o = ACT_RECHECK;
            else                       act_o = ACT_NEW_ROUND;
         end
         PH_RECHK_B: act_o = tog_same ? ACT_PASS : ACT_FAIL;
         default:    act_o = ACT_NEXT;
      endcase
   end

endmodule

// File: rtl/ftp_read_seq.sv
module ftp_read_seq
   import ftp_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  poll_act_e         act_i,
   input  logic              expired_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output rd_phase_e         phase_o,
   output logic [DATA_W-1:0] held_o,
   output logic              clear_o,
   output logic              run_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o
);

   seq_state_e        state_q;
   rd_phase_e         phase_q;
   logic [DATA_W-1:0] held_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;
   logic              pass_q;
   logic              finish;
   logic              fin_pass;

   // a verdict carried by the arriving read outranks the timer (R7)
   always_comb begin
      finish   = 1'b0;
      fin_pass = 1'b0;
      case (state_q)
         ST_REQ:  finish = expired_i;
         ST_WAIT: begin
            if (rd_valid_i && act_i == ACT_PASS) begin
               finish   = 1'b1;
               fin_pass = 1'b1;
            end else if (rd_valid_i && act_i == ACT_FAIL) begin
               finish   = 1'b1;
            end else begin
               finish   = expired_i;
            end
         end
         default: finish = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         phase_q <= PH_DUMMY;
         held_q  <= '0;
         addr_q  <= '0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (finish) pass_q <= fin_pass;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  addr_q  <= addr_i;
                  phase_q <= PH_DUMMY;
                  pass_q  <= 1'b0;
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: state_q <= finish ? ST_IDLE : ST_WAIT;
            ST_WAIT: begin
               if (finish) begin
                  state_q <= ST_IDLE;
               end else if (rd_valid_i) begin
                  state_q <= ST_REQ;
                  case (act_i)
                     ACT_NEW_ROUND: phase_q <= PH_DUMMY;
                     ACT_RECHECK:   phase_q <= PH_RECHK_A;
                     default: begin
                        phase_q <= phase_after(phase_q);
                        if (phase_q == PH_KEEP_A || phase_q == PH_RECHK_A)
                           held_q <= rd_data_i;
                     end
                  endcase
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign clear_o   = (state_q == ST_IDLE) && start_i;
   assign run_o     = busy_o && !finish;
   assign rd_req_o  = (state_q == ST_REQ) && !finish;
   assign rd_addr_o = addr_q;
   assign phase_o   = phase_q;
   assign held_o    = held_q;
   assign done_o    = done_q;
   assign pass_o    = pass_q;

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
   import ftp_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 16,
   parameter int CNT_W        = 32,
   parameter int TOG_POS      = 6,
   parameter int LIM_POS      = 5,
   parameter int TICKS_PER_MS = 50000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  limit_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic [CNT_W-1:0]  elapsed_o
);

   localparam longint unsigned SECTOR_TICKS = ms_to_ticks(SECTOR_LIMIT_MS, TICKS_PER_MS);
   localparam longint unsigned ARRAY_TICKS  = ms_to_ticks(ARRAY_LIMIT_MS, TICKS_PER_MS);
   localparam longint unsigned CNT_SPAN     = (CNT_W >= 63) ? 64'hFFFF_FFFF_FFFF_FFFF
                                                            : (64'd1 << CNT_W);

   generate
      if (ARRAY_TICKS >= CNT_SPAN || SECTOR_TICKS >= CNT_SPAN) begin : g_bad_cnt
         $error("flash_toggle_poller: CNT_W too small for the preset time limits");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("flash_toggle_poller: ADDR_W cannot reach the whole-array poll offset");
      end
   endgenerate

   poll_act_e         act;
   rd_phase_e         phase;
   logic [DATA_W-1:0] held;
   logic              expired;
   logic              tmr_clear;
   logic              tmr_run;
   logic [CNT_W-1:0]  tmr_limit;

   ftp_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .addr_i     (addr_i),
      .rd_valid_i (rd_valid_i),
      .rd_data_i  (rd_data_i),
      .act_i      (act),
      .expired_i  (expired),
      .rd_req_o   (rd_req_o),
      .rd_addr_o  (rd_addr_o),
      .phase_o    (phase),
      .held_o     (held),
      .clear_o    (tmr_clear),
      .run_o      (tmr_run),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .pass_o     (pass_o)
   );

   ftp_toggle_judge #(.DATA_W(DATA_W), .TOG_POS(TOG_POS), .LIM_POS(LIM_POS)) u_judge (
      .phase_i (phase),
      .held_i  (held),
      .fresh_i (rd_data_i),
      .act_o   (act)
   );

   ftp_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .clear_i   (tmr_clear),
      .run_i     (tmr_run),
      .limit_i   (limit_i),
      .elapsed_o (elapsed_o),
      .limit_o   (tmr_limit),
      .expired_o (expired)
   );

endmodule

// File: rtl/ftp_poll_checker.sv
module ftp_poll_checker #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              busy_o,
   input logic              rd_req_o,
   input logic              done_o,
   input logic              pass_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic [CNT_W-1:0]  elapsed_o,
   input logic [CNT_W-1:0]  lim
);

   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
      rd_req_o |-> busy_o);                                              // R2
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      rd_req_o |=> !rd_req_o);                                           // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);                                               // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o);                                               // R8
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && $past(!busy_o)) |-> ($stable(pass_o) && $stable(elapsed_o))); // R8
   AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
      (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));                 // R9
   AST_ELAPSED_BOUND: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> ({1'b0, elapsed_o} <= {1'b0, lim} + 1'b1));             // R6

endmodule

bind flash_toggle_poller ftp_poll_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .busy_o    (busy_o),
   .rd_req_o  (rd_req_o),
   .done_o    (done_o),
   .pass_o    (pass_o),
   .rd_addr_o (rd_addr_o),
   .elapsed_o (elapsed_o),
   .lim       (tmr_limit)
);

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
   localparam int ADDR_W = 20;
   localparam int DATA_W = 16;
   localparam int CNT_W  = 32;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [CNT_W-1:0]  limit_i = '0;
   logic              rd_req_o;
   logic [ADDR_W-1:0] rd_addr_o;
   logic              rd_valid_i = 1'b0;
   logic [DATA_W-1:0] rd_data_i = '0;
   logic              busy_o, done_o, pass_o;
   logic [CNT_W-1:0]  elapsed_o;

   always #4 clk = ~clk;

   flash_toggle_poller i_flash_toggle_poller (
      .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .limit_i(limit_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
      .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
      .elapsed_o(elapsed_o)
   );

   int errors = 0, checks = 0, resp_err = 0, resp_chk = 0;

   // responder scenario
   int                sc_tog = 0;
   int                sc_lim = 1000;
   bit                sc_sticky = 1'b0;
   int                lat_fix = 2;
   logic [ADDR_W-1:0] run_addr = '0;
   bit                resp_clear = 1'b0;
   bit                stray_go = 1'b0;
   int                rd_idx = 0;
   bit                pend = 1'b0;
   int                cnt = 0;

   function automatic logic [15:0] word_at(input int i);
      logic [15:0] w;
      w    = 16'h9A15;
      w[6] = (sc_sticky || i < sc_tog) ? i[0] : 1'b0;
      w[5] = (i >= sc_lim);
      return w;
   endfunction

   always @(posedge clk) begin
      rd_valid_i <= 1'b0;
      if (rst || resp_clear) begin
         pend <= 1'b0;
         cnt  <= 0;
         if (resp_clear) rd_idx <= 0;
      end else begin
         if (pend) begin
            if (cnt <= 1) begin
               rd_valid_i <= 1'b1;
               rd_data_i  <= word_at(rd_idx);
               rd_idx     <= rd_idx + 1;
               pend       <= 1'b0;
            end else begin
               cnt <= cnt - 1;
            end
         end
         if (stray_go) begin
            rd_valid_i <= 1'b1;
            rd_data_i  <= 16'h0060;
         end
         if (rd_req_o) begin
            resp_chk = resp_chk + 1;
            if (pend) begin
               resp_err = resp_err + 1;
               $display("FAIL R2 second request while one outstanding: actual=1 expected=0");
            end
            if (rd_addr_o != run_addr) begin
               resp_err = resp_err + 1;
               $display("FAIL R2/R9 read address: actual=%h expected=%h", rd_addr_o, run_addr);
            end
            pend <= 1'b1;
            cnt  <= (lat_fix > 0) ? lat_fix : int'(1 + ($urandom % 4));
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference replay of the polling rules on the responder's word sequence
   task automatic model(output bit pass, output int reads, output bit tmo);
      int idx;
      logic [15:0] a, b, c, d;
      idx = 0; pass = 1'b0; tmo = 1'b1;
      for (int r = 0; r < 200; r++) begin
         idx = idx + 1;
         a = word_at(idx); b = word_at(idx + 1); idx = idx + 2;
         if (a[6] == b[6]) begin pass = 1'b1; tmo = 1'b0; break; end
         if (a[5]) begin
            c = word_at(idx); d = word_at(idx + 1); idx = idx + 2;
            pass = (c[6] == d[6]); tmo = 1'b0; break;
         end
      end
      reads = idx;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors + resp_err, checks + resp_chk);
   endtask

   // one poll; intrude > 0 pulses a foreign start at that cycle of the run
   task automatic run(input int limit, input logic [ADDR_W-1:0] addr, input int lat,
                      input int intrude, output int el_meas);
      int k;
      @(negedge clk);
      lat_fix = lat; run_addr = addr; resp_clear = 1'b1;
      @(negedge clk);
      resp_clear = 1'b0;
      addr_i = addr; limit_i = CNT_W'(limit); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
      k = 0;
      while (k < 20000) begin
         @(negedge clk);
         k++;
         if (k == intrude) begin start_i = 1'b1; addr_i = addr ^ 20'h0F0F0; limit_i = 0; end
         else start_i = 1'b0;
         if (done_o) break;
      end
      start_i = 1'b0;
      el_meas = k - 1;
      @(negedge clk);
      chk(done_o == 1'b0, "R8", "done pulse width", done_o, 0);
   endtask

   task automatic scen(input string req, input int tog, input int lim, input bit sticky,
                       input int limit, input int lat, input int intrude);
      bit ep, et; int er, el;
      sc_tog = tog; sc_lim = lim; sc_sticky = sticky;
      model(ep, er, et);
      run(limit, 20'(($urandom % 20'hFFFFF) & 20'hFFFFE), lat, intrude, el);
      if (et) begin
         chk(pass_o == 1'b0, "R6", "timeout verdict", pass_o, 0);
         chk(elapsed_o == CNT_W'(limit + 1), "R6", "timeout elapsed", elapsed_o, limit + 1);
      end else begin
         chk(pass_o == ep, req, "verdict", pass_o, ep);
         chk(rd_idx == er, req, "reads issued (R2)", rd_idx, er);
         chk(elapsed_o == CNT_W'(el), "R8", "elapsed count", elapsed_o, el);
      end
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int e_ref, el;
      logic [CNT_W-1:0] keep_el;
      logic keep_pass;
      void'($urandom(32'h5EED_0042));
      repeat (5) @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && pass_o == 0 && rd_req_o == 0, "R1",
          "idle outputs in reset", {busy_o, done_o, pass_o, rd_req_o}, 0);
      chk(elapsed_o == 0, "R1", "elapsed in reset", elapsed_o, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      // directed verdict paths
      scen("R3", 0, 1000, 0, 5000, 0, 0);   // still at once: pass after 3 reads
      scen("R5", 4, 1000, 0, 5000, 0, 0);   // one toggling round, then pass
      scen("R4", 3, 0, 0, 5000, 2, 0);      // flag set, recheck settles: pass
      scen("R4", 0, 0, 1, 5000, 1, 0);      // flag set, still toggling: fail
      scen("R6", 0, 1000, 1, 60, 0, 0);     // endless toggling: timeout
      scen("R6", 0, 1000, 1, 0, 0, 0);      // zero limit
      scen("R9", 6, 1000, 0, 5000, 2, 3);   // foreign start while busy

      // timeout and final read on the same edge
      sc_tog = 0; sc_lim = 1000; sc_sticky = 0;
      run(1000, 20'h00AA8, 2, 0, e_ref);
      chk(pass_o == 1, "R7", "reference pass", pass_o, 1);
      repeat (6) @(negedge clk);
      run(e_ref, 20'h00AA8, 2, 0, el);
      chk(pass_o == 1, "R7", "limit E: pass", pass_o, 1);
      repeat (6) @(negedge clk);
      run(e_ref - 1, 20'h00AA8, 2, 0, el);
      chk(pass_o == 1, "R7", "coincident edge: verdict wins", pass_o, 1);
      chk(elapsed_o == CNT_W'(e_ref), "R7", "coincident elapsed", elapsed_o, e_ref);
      repeat (6) @(negedge clk);
      run(e_ref - 2, 20'h00AA8, 2, 0, el);
      chk(pass_o == 0, "R7", "timeout one edge early: fail", pass_o, 0);
      chk(elapsed_o == CNT_W'(e_ref - 1), "R7", "early timeout elapsed", elapsed_o, e_ref - 1);
      repeat (6) @(negedge clk);

      // held result and stray valid while idle
      keep_el = elapsed_o; keep_pass = pass_o;
      stray_go = 1'b1;
      @(negedge clk);
      stray_go = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(busy_o == 0 && done_o == 0, "R10", "stray valid idle",
             {busy_o, done_o}, 0);
      end
      chk(elapsed_o == keep_el && pass_o == keep_pass, "R8",
          "result held while idle (R10)", elapsed_o, keep_el);

      // random polls
      for (int n = 0; n < 40; n++) begin
         scen((($urandom % 5) == 0) ? "R4" : "R3",
              int'($urandom % 9), int'($urandom % 11), (($urandom % 5) == 0), 5000, 0, 0);
      end

      // reset in the middle of a poll
      sc_tog = 0; sc_lim = 1000; sc_sticky = 1;
      @(negedge clk);
      lat_fix = 0; run_addr = 20'h01234; resp_clear = 1'b1;
      @(negedge clk);
      resp_clear = 1'b0; addr_i = 20'h01234; limit_i = 5000; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && pass_o == 0 && rd_req_o == 0, "R1",
          "outputs after mid-poll reset", {busy_o, done_o, pass_o, rd_req_o}, 0);
      chk(elapsed_o == 0, "R1", "elapsed after mid-poll reset", elapsed_o, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      summary();
      $finish;
   end

endmodule